// File: doc/BRIEF.md
# Dual-Address Block Transfer Channel

This block is a single-channel DMA engine that moves a block of bytes from a source region to a destination region on a 16-bit bus with upper and lower byte strobes. A host programs a source pointer, a destination pointer, a byte count and a configuration word through a small register port, then writes a start command. The channel then moves the block one operand at a time. Each operand is read from the source into an internal 16-bit holding register and then written from that register to the destination. When the count runs out, the channel returns to idle, sets a done flag and, if enabled, raises an interrupt.

Each side is set up on its own. It can be byte or word sized, and its pointer can step or stay fixed. When the two sides differ in size, the operand is two bytes wide. The byte side then uses two byte cycles. A word side at an odd address also falls back to two byte cycles. The bus is big-endian: an even address uses the upper lane (bits 15:8) and an odd address uses the lower lane (bits 7:0). Every bus cycle holds its outputs until `bus_ack` is sampled high.

The sequencer has four states. IDLE goes to WAIT when a start is accepted with a non-zero count. WAIT goes to READ when an operand request is present: always in internal mode, or when `dreq` is high in external mode. READ goes to WRITE on the acknowledge of the last read cycle of the operand. WRITE goes back to WAIT on the acknowledge of the last write cycle if bytes remain. It goes to IDLE, raising the done flag, when the count reaches zero.

Top module: `dma_chan`

## Requirements
- R1: After reset, all registers read zero, the status reads zero, `irq` is low and no bus cycle is active.
- R2: Register offsets are 0 source pointer, 1 destination pointer, 2 byte count, 3 configuration, 4 command/status.
  - Configuration bits: 0 source word, 1 source step, 2 destination word, 3 destination step, 4 external request mode, 5 interrupt enable, 8:6 source function code, 11:9 destination function code.
  - Command write bits: 0 clears done, 1 clears the configuration error, 4 starts the channel.
  - Status read bits: 0 done, 1 configuration error, 2 busy.
  - While busy, host writes to offsets 0 to 3 and start commands have no effect.
- R3: Every operand is a complete source read followed by a complete destination write. Each bus cycle holds address, direction, strobes, function code and write data until `bus_ack` is sampled high.
- R4: Read cycles drive the source pointer and the source function code. Write cycles drive the destination pointer and the destination function code. A byte cycle enables only the lane selected by address bit 0 (even selects the upper lane).
- R5: The operand is two bytes when either side is word sized and at least two bytes remain; otherwise it is one byte. A side performs a single word cycle only when it is word sized, the operand is two bytes and its address is even. Otherwise it performs one byte cycle per operand byte, with the first byte going to or from bits 15:8 of the holding register.
- R6: After each acknowledged cycle on a side whose step bit is set, that side's pointer advances by the bytes moved (2 for a word cycle, 1 for a byte cycle). A side whose step bit is clear keeps its pointer unchanged.
- R7: After the last write cycle of an operand, the byte count decreases by the operand size.
- R8: When the count reaches zero, busy clears and done sets. `irq` equals done AND interrupt enable. Writing command bit 0 clears done, and `irq` with it.
- R9: A start with both step bits clear and either pointer odd does not start the channel. It sets the configuration error flag and produces no bus cycle.
- R10: In external request mode, a new operand starts only while `dreq` is high. In internal mode, operands follow one another without waiting.
- R11: A start with a zero count sets done at once and produces no bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Host register write strobe |
| reg_addr | input | 3 | Host register offset |
| reg_wdata | input | AW | Host write data |
| reg_rdata | output | AW | Host read data for `reg_addr` |
| dreq | input | 1 | External operand request |
| bus_cyc | output | 1 | Bus cycle active |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | AW | Byte address |
| bus_fc | output | 3 | Function code of the cycle |
| bus_ube | output | 1 | Upper lane (15:8) strobe |
| bus_lbe | output | 1 | Lower lane (7:0) strobe |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | Cycle acknowledge |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets word sides at odd addresses. A design that kept using the word path after the first byte would issue a misplaced word cycle halfway through the operand. It also targets an odd final byte behind a word side, which a wrong design would move as a two-byte operand, overrunning the count. A fixed-address byte source feeding a stepping word destination checks that a non-stepping pointer stays put. Host writes during a slow transfer check that the loaded pointers and count are protected; a failure shows as wrong addresses and a wrong final pointer. Further cases cover a rejected odd non-stepping start, a zero-length start and external request gating, which would show up as stray bus cycles, a missing done flag or operands that run ahead of `dreq`.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_WAIT,
        S_READ,
        S_WRITE
    } seq_state_t;

    typedef struct packed {
        logic [2:0] dst_fc;
        logic [2:0] src_fc;
        logic       irq_en;
        logic       ext_req;
        logic       dst_inc;
        logic       dst_word;
        logic       src_inc;
        logic       src_word;
    } chan_cfg_t;

    localparam int CFG_W = $bits(chan_cfg_t);

    localparam logic [2:0] RA_SRC = 3'd0;
    localparam logic [2:0] RA_DST = 3'd1;
    localparam logic [2:0] RA_CNT = 3'd2;
    localparam logic [2:0] RA_CFG = 3'd3;
    localparam logic [2:0] RA_CMD = 3'd4;

    localparam int CMD_CLR_DONE = 0;
    localparam int CMD_CLR_ERR  = 1;
    localparam int CMD_START    = 4;

endpackage

// File: rtl/dma_ptr.sv
module dma_ptr #(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          adv,
    input  logic [1:0]    step,
    output logic [AW-1:0] ptr
);

    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (load)
            ptr <= load_val;
        else if (adv)
            ptr <= ptr + AW'(step);
    end

endmodule

// File: rtl/dma_lane.sv
module dma_lane (
    input  logic [15:0] rdata,
    input  logic [15:0] hold,
    input  logic        beat,
    input  logic        word_beat,
    input  logic        a0,
    output logic [15:0] hold_nxt,
    output logic [15:0] wdata,
    output logic        ube,
    output logic        lbe
);

    logic [7:0] rd_byte;
    logic [7:0] wr_byte;

    always_comb begin
        rd_byte = a0 ? rdata[7:0] : rdata[15:8];
        wr_byte = beat ? hold[7:0] : hold[15:8];
        if (word_beat)
            hold_nxt = rdata;
        else if (beat)
            hold_nxt = {hold[15:8], rd_byte};
        else
            hold_nxt = {rd_byte, hold[7:0]};
        wdata = word_beat ? hold : {wr_byte, wr_byte};
        ube   = word_beat | ~a0;
        lbe   = word_beat | a0;
    end

endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [CW-1:0] cnt,
    input  logic          src_word,
    input  logic          dst_word,
    input  logic          ext_req,
    input  logic          dreq,
    input  logic          ack,
    input  logic          src_a0,
    input  logic          dst_a0,
    output seq_state_t    state,
    output logic          beat,
    output logic          op2,
    output logic          word_beat,
    output logic          last_beat,
    output logic          rd_ack,
    output logic          wr_ack,
    output logic          finish,
    output logic          bus_cyc,
    output logic          bus_we
);

    seq_state_t nxt;
    logic       op_req;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= nxt;
    end

    // operand width and beat index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat <= 1'b0;
            op2  <= 1'b0;
        end else if (state == S_WAIT && op_req) begin
            beat <= 1'b0;
            op2  <= (src_word | dst_word) && (cnt > CW'(1));
        end else if (rd_ack || wr_ack) begin
            beat <= ~last_beat;
        end
    end

    // outputs
    always_comb begin
        op_req    = ~ext_req | dreq;
        bus_cyc   = (state == S_READ) || (state == S_WRITE);
        bus_we    = (state == S_WRITE);
        word_beat = 1'b0;
        unique case (state)
            S_READ:  word_beat = src_word && op2 && !src_a0 && !beat;
            S_WRITE: word_beat = dst_word && op2 && !dst_a0 && !beat;
            default: word_beat = 1'b0;
        endcase
        last_beat = word_beat | ~op2 | beat;
        rd_ack    = (state == S_READ) && ack;
        wr_ack    = (state == S_WRITE) && ack;
        finish    = wr_ack && last_beat && (cnt == (op2 ? CW'(2) : CW'(1)));
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (go) nxt = S_WAIT;
            S_WAIT:  if (op_req) nxt = S_READ;
            S_READ:  if (rd_ack && last_beat) nxt = S_WRITE;
            S_WRITE: if (wr_ack && last_beat) nxt = finish ? S_IDLE : S_WAIT;
        endcase
    end

    // R10
    ext_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT && ext_req && !dreq) |=> (state == S_WAIT));

    // R3
    read_before_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_we) |-> $past(state == S_READ && ack));

endmodule

// File: rtl/dma_chan.sv
module dma_chan
    import dma_pkg::*;
#(
    parameter int AW = 24,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] reg_rdata,
    input  logic          dreq,
    output logic          bus_cyc,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [2:0]    bus_fc,
    output logic          bus_ube,
    output logic          bus_lbe,
    output logic [15:0]   bus_wdata,
    input  logic [15:0]   bus_rdata,
    input  logic          bus_ack,
    output logic          irq
);

    chan_cfg_t     cfg_q;
    logic [CW-1:0] cnt_q;
    logic          done_q, err_q;
    logic [15:0]   hold_q, hold_nxt;
    logic [AW-1:0] src_ptr, dst_ptr;
    seq_state_t    state;
    logic          beat, op2, word_beat, last_beat, rd_ack, wr_ack, finish;
    logic          busy, start_req, bad_cfg, go, zero_done, lane_a0;
    logic [1:0]    src_step, dst_step;
    logic          wr_src, wr_dst, wr_cnt, wr_cfg, wr_cmd;

    always_comb begin
        busy      = (state != S_IDLE);
        wr_src    = reg_we && reg_addr == RA_SRC && !busy;
        wr_dst    = reg_we && reg_addr == RA_DST && !busy;
        wr_cnt    = reg_we && reg_addr == RA_CNT && !busy;
        wr_cfg    = reg_we && reg_addr == RA_CFG && !busy;
        wr_cmd    = reg_we && reg_addr == RA_CMD;
        start_req = wr_cmd && reg_wdata[CMD_START] && !busy;
        bad_cfg   = !cfg_q.src_inc && !cfg_q.dst_inc && (src_ptr[0] | dst_ptr[0]);
        go        = start_req && !bad_cfg && (cnt_q != '0);
        zero_done = start_req && !bad_cfg && (cnt_q == '0);
        src_step  = cfg_q.src_inc ? (word_beat ? 2'd2 : 2'd1) : 2'd0;
        dst_step  = cfg_q.dst_inc ? (word_beat ? 2'd2 : 2'd1) : 2'd0;
        lane_a0   = bus_we ? dst_ptr[0] : src_ptr[0];
        bus_addr  = bus_cyc ? (bus_we ? dst_ptr : src_ptr) : '0;
        bus_fc    = bus_cyc ? (bus_we ? cfg_q.dst_fc : cfg_q.src_fc) : 3'd0;
        irq       = done_q & cfg_q.irq_en;
    end

    dma_ptr #(.AW(AW)) src_ptr_i (
        .clk(clk), .rst_n(rst_n), .load(wr_src), .load_val(reg_wdata),
        .adv(rd_ack), .step(src_step), .ptr(src_ptr)
    );

    dma_ptr #(.AW(AW)) dst_ptr_i (
        .clk(clk), .rst_n(rst_n), .load(wr_dst), .load_val(reg_wdata),
        .adv(wr_ack), .step(dst_step), .ptr(dst_ptr)
    );

    dma_seq #(.CW(CW)) seq_i (
        .clk(clk), .rst_n(rst_n), .go(go), .cnt(cnt_q),
        .src_word(cfg_q.src_word), .dst_word(cfg_q.dst_word),
        .ext_req(cfg_q.ext_req), .dreq(dreq), .ack(bus_ack),
        .src_a0(src_ptr[0]), .dst_a0(dst_ptr[0]),
        .state(state), .beat(beat), .op2(op2), .word_beat(word_beat),
        .last_beat(last_beat), .rd_ack(rd_ack), .wr_ack(wr_ack),
        .finish(finish), .bus_cyc(bus_cyc), .bus_we(bus_we)
    );

    dma_lane lane_i (
        .rdata(bus_rdata), .hold(hold_q), .beat(beat), .word_beat(word_beat),
        .a0(lane_a0), .hold_nxt(hold_nxt), .wdata(bus_wdata),
        .ube(bus_ube), .lbe(bus_lbe)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            hold_q <= '0;
        end else begin
            if (wr_cfg)
                cfg_q <= chan_cfg_t'(reg_wdata[CFG_W-1:0]);
            if (wr_cnt)
                cnt_q <= reg_wdata[CW-1:0];
            else if (wr_ack && last_beat)
                cnt_q <= cnt_q - (op2 ? CW'(2) : CW'(1));
            if (finish || zero_done)
                done_q <= 1'b1;
            else if (wr_cmd && reg_wdata[CMD_CLR_DONE])
                done_q <= 1'b0;
            if (start_req && bad_cfg)
                err_q <= 1'b1;
            else if (wr_cmd && (reg_wdata[CMD_CLR_ERR] || reg_wdata[CMD_START]))
                err_q <= 1'b0;
            if (rd_ack)
                hold_q <= hold_nxt;
        end
    end

    always_comb begin
        unique case (reg_addr)
            RA_SRC:  reg_rdata = src_ptr;
            RA_DST:  reg_rdata = dst_ptr;
            RA_CNT:  reg_rdata = AW'(cnt_q);
            RA_CFG:  reg_rdata = AW'(cfg_q);
            RA_CMD:  reg_rdata = AW'({busy, err_q, done_q});
            default: reg_rdata = '0;
        endcase
    end

    // R3
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && !bus_ack) |=> (bus_cyc && $stable(bus_addr) && $stable(bus_we)
            && $stable(bus_fc) && $stable(bus_ube) && $stable(bus_lbe) && $stable(bus_wdata)));

    // R7
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy && (cnt_q != $past(cnt_q)))
            |-> (($past(cnt_q) - cnt_q) == CW'(1) || ($past(cnt_q) - cnt_q) == CW'(2)));

    // R8
    done_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done_q);

    // R9
    cfg_err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> !busy);

    // R6
    src_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bus_ack) |=> $stable(src_ptr) && $stable(dst_ptr));

endmodule

// File: tb/dma_chan_tb_top.sv
module dma_chan_tb_top;

    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [AW-1:0] reg_wdata = '0;
    logic [AW-1:0] reg_rdata;
    logic          dreq = 1'b0;
    logic          bus_cyc, bus_we, bus_ube, bus_lbe, irq;
    logic [AW-1:0] bus_addr;
    logic [2:0]    bus_fc;
    logic [15:0]   bus_wdata;
    logic [15:0]   bus_rdata = '0;
    logic          bus_ack = 1'b0;

    always #5 clk = ~clk;

    dma_chan #(.AW(AW), .CW(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq),
        .bus_cyc(bus_cyc), .bus_we(bus_we), .bus_addr(bus_addr), .bus_fc(bus_fc),
        .bus_ube(bus_ube), .bus_lbe(bus_lbe), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .irq(irq)
    );

    typedef struct {
        bit        we;
        int        addr;
        bit        ube;
        bit        lbe;
        int        fc;
        bit [15:0] data;
    } xf_t;

    xf_t        exp_q[$];
    logic [7:0] mem     [0:255];
    logic [7:0] exp_mem [0:255];
    int         errors = 0;
    int         checks = 0;
    int         ws = 0;
    int         wcnt = 0;
    int         cyc_cnt = 0;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // behavioural memory with programmable wait states
    always @(posedge clk) begin
        if (!rst_n) begin
            bus_ack <= 1'b0;
        end else if (bus_ack) begin
            bus_ack <= 1'b0;
            wcnt    <= ws;
        end else if (bus_cyc) begin
            if (wcnt > 0) begin
                wcnt <= wcnt - 1;
            end else begin
                bus_ack <= 1'b1;
                if (!bus_we)
                    bus_rdata <= {mem[{bus_addr[7:1], 1'b0}], mem[{bus_addr[7:1], 1'b1}]};
                else begin
                    if (bus_ube) mem[{bus_addr[7:1], 1'b0}] <= bus_wdata[15:8];
                    if (bus_lbe) mem[{bus_addr[7:1], 1'b1}] <= bus_wdata[7:0];
                end
            end
        end
    end

    // every acknowledged cycle is compared with the model's next expected cycle
    always @(negedge clk) begin
        if (rst_n && bus_cyc && bus_ack) begin
            if (exp_q.size() == 0) begin
                chk("R3", "unexpected bus cycle addr", 64'(bus_addr), 64'hFFFF_FFFF);
            end else begin
                xf_t e;
                logic [15:0] m;
                e = exp_q.pop_front();
                m = {{8{e.ube}}, {8{e.lbe}}};
                chk(e.we ? "R5 write" : "R4 read", "cycle {we,ube,lbe,fc,addr,data}",
                    64'({bus_we, bus_ube, bus_lbe, bus_fc, bus_addr, (bus_we ? bus_wdata & m : 16'h0)}),
                    64'({e.we, e.ube, e.lbe, 3'(e.fc), 24'(e.addr), (e.we ? e.data & m : 16'h0)}));
            end
        end
    end

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 150000) begin
            errors++;
            checks++;
            $display("FAIL R3 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic reg_wr(input logic [2:0] a, input int d);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = a;
        reg_wdata = AW'(d);
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output int d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = int'(reg_rdata);
    endtask

    task automatic wait_idle();
        int st;
        for (int i = 0; i < 5000; i++) begin
            reg_rd(3'd4, st);
            if (st[2] == 1'b0) break;
        end
    endtask

    function automatic logic [11:0] cfgw(bit sw, bit si, bit dw, bit di, bit ext, bit ie, int sfc, int dfc);
        return {3'(dfc), 3'(sfc), ie, ext, di, dw, si, sw};
    endfunction

    // behavioural transfer model: expected cycle list, final pointers, memory image
    task automatic model(input int s0, input int d0, input int n0, input logic [11:0] c,
                         output int fs, output int fd);
        int s, d, n, op;
        logic [7:0] b [2];
        s = s0; d = d0; n = n0;
        for (int i = 0; i < 256; i++) exp_mem[i] = mem[i];
        while (n > 0) begin
            op = ((c[0] || c[2]) && n >= 2) ? 2 : 1;
            if (c[0] && op == 2 && s % 2 == 0) begin
                b[0] = exp_mem[s & 255];
                b[1] = exp_mem[(s + 1) & 255];
                exp_q.push_back('{1'b0, s, 1'b1, 1'b1, int'(c[8:6]), 16'h0});
                if (c[1]) s += 2;
            end else begin
                for (int k = 0; k < op; k++) begin
                    b[k] = exp_mem[s & 255];
                    exp_q.push_back('{1'b0, s, (s % 2 == 0), (s % 2 == 1), int'(c[8:6]), 16'h0});
                    if (c[1]) s += 1;
                end
            end
            if (c[2] && op == 2 && d % 2 == 0) begin
                exp_mem[d & 255]       = b[0];
                exp_mem[(d + 1) & 255] = b[1];
                exp_q.push_back('{1'b1, d, 1'b1, 1'b1, int'(c[11:9]), {b[0], b[1]}});
                if (c[3]) d += 2;
            end else begin
                for (int k = 0; k < op; k++) begin
                    exp_mem[d & 255] = b[k];
                    exp_q.push_back('{1'b1, d, (d % 2 == 0), (d % 2 == 1), int'(c[11:9]), {b[k], b[k]}});
                    if (c[3]) d += 1;
                end
            end
            n -= op;
        end
        fs = s;
        fd = d;
    endtask

    task automatic run(input int s, input int d, input int n, input logic [11:0] c,
                       input bit exp_irq, input int req_delay, input bit poke);
        int fs, fd, v, mism, qn;
        reg_wr(3'd0, s);
        reg_wr(3'd1, d);
        reg_wr(3'd2, n);
        reg_wr(3'd3, int'(c));
        wcnt = ws;
        model(s, d, n, c, fs, fd);
        qn = exp_q.size();
        reg_wr(3'd4, 32'h10);
        if (req_delay > 0) begin
            repeat (req_delay) @(negedge clk);
            chk("R10", "cycles left while dreq low", 64'(exp_q.size()), 64'(qn));
            reg_rd(3'd4, v);
            chk("R10", "busy while waiting for dreq", 64'(v[2]), 64'd1);
            dreq = 1'b1;
        end
        if (poke) begin
            repeat (4) @(negedge clk);
            reg_wr(3'd0, 32'h99);
            reg_wr(3'd2, 32'h50);
            reg_wr(3'd3, 0);
        end
        wait_idle();
        dreq = 1'b0;
        chk("R3", "cycles not seen", 64'(exp_q.size()), 64'd0);
        exp_q.delete();
        reg_rd(3'd0, v); chk("R6", "final source pointer", 64'(v), 64'(fs));
        reg_rd(3'd1, v); chk("R6", "final destination pointer", 64'(v), 64'(fd));
        reg_rd(3'd2, v); chk("R7", "final count", 64'(v), 64'd0);
        if (poke) begin
            reg_rd(3'd3, v); chk("R2", "config after busy write", 64'(v), 64'(c));
        end
        reg_rd(3'd4, v); chk("R8", "status at end", 64'(v), 64'd1);
        chk("R8", "irq at end", 64'(irq), 64'(exp_irq));
        mism = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) mism++;
        chk("R5", "memory bytes differing", 64'(mism), 64'd0);
        reg_wr(3'd4, 1);
        reg_rd(3'd4, v); chk("R8", "done after clear", 64'(v), 64'd0);
        chk("R8", "irq after clear", 64'(irq), 64'd0);
    endtask

    initial begin
        int v;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_rd(3'd4, v); chk("R1", "status after reset", 64'(v), 64'd0);
        reg_rd(3'd0, v); chk("R1", "source after reset", 64'(v), 64'd0);
        reg_rd(3'd2, v); chk("R1", "count after reset", 64'(v), 64'd0);
        chk("R1", "irq/cyc after reset", 64'({irq, bus_cyc}), 64'd0);

        // R4 byte to byte, both stepping, odd count, interrupt enabled
        run(32'h10, 32'h90, 3, cfgw(0, 1, 0, 1, 0, 1, 5, 1), 1'b1, 0, 1'b0);
        // R5 word source to byte destination at odd address
        ws = 1;
        run(32'h20, 32'hA1, 4, cfgw(1, 1, 0, 1, 0, 1, 2, 6), 1'b1, 0, 1'b0);
        // R6 fixed byte source feeding stepping word destination, interrupt off
        ws = 0;
        run(32'h41, 32'hB0, 4, cfgw(0, 0, 1, 1, 0, 0, 3, 4), 1'b0, 0, 1'b0);
        // R5 odd word source, even word destination, odd count
        run(32'h31, 32'hC0, 5, cfgw(1, 1, 1, 1, 0, 1, 1, 7), 1'b1, 0, 1'b0);

        // R9 both fixed with odd pointer: rejected
        reg_wr(3'd0, 32'h51);
        reg_wr(3'd1, 32'hD0);
        reg_wr(3'd2, 2);
        reg_wr(3'd3, int'(cfgw(0, 0, 0, 0, 0, 1, 0, 0)));
        reg_wr(3'd4, 32'h10);
        repeat (10) @(negedge clk);
        reg_rd(3'd4, v); chk("R9", "status after bad start", 64'(v), 64'd2);
        reg_rd(3'd2, v); chk("R9", "count untouched", 64'(v), 64'd2);
        reg_wr(3'd4, 2);
        reg_rd(3'd4, v); chk("R9", "status after error clear", 64'(v), 64'd0);

        // R11 zero count
        reg_wr(3'd1, 32'hD2);
        reg_wr(3'd2, 0);
        reg_wr(3'd3, int'(cfgw(0, 1, 0, 1, 0, 1, 0, 0)));
        reg_wr(3'd4, 32'h10);
        repeat (5) @(negedge clk);
        reg_rd(3'd4, v); chk("R11", "status after zero start", 64'(v), 64'd1);
        chk("R11", "irq after zero start", 64'(irq), 64'd1);
        reg_wr(3'd4, 1);

        // R10 external request gating
        run(32'h70, 32'hF0, 4, cfgw(1, 1, 1, 1, 1, 1, 2, 3), 1'b1, 20, 1'b0);

        // R2 host writes while busy are ignored
        ws = 3;
        run(32'h60, 32'hE0, 6, cfgw(0, 1, 0, 1, 0, 1, 4, 5), 1'b1, 0, 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule